// File: doc/BRIEF.md
# Serial-Bus Wiper Register Slave

This block is a two-wire serial-bus slave that owns the wiper setting of a digital potentiometer. It watches SCL and SDA, which it synchronises to its own clock. It answers its own address and controls SDA only through an open-drain pull-down enable. The address-select pin supplies the lowest address bit, so two copies can share one bus and still be reached separately.

A write transfer has three parts: the address byte, one instruction byte, and then any number of data bytes. Every data byte applies the instruction again, which lets the master step the wiper several times after a single addressing phase. A read transfer sends the wiper value back, and the value repeats for as long as the master keeps acknowledging. A new instruction requires a fresh START.

Top module: `dpot_i2c_slave`

## Requirements
- R1: While reset is held and right after it is released, `wiper_o` is midscale (0x80 for the default 8-bit width), `shdn_o` is 0 and `sda_oe_o` is 0.
- R2: The 7-bit slave address is 0b010110 followed by `addr_sel_i`. The address byte sends that address MSB first, and its last bit is 1 for read or 0 for write. On a match the slave pulls SDA low during the ninth clock. On a mismatch it never pulls SDA low and changes no state until the next START.
- R3: The slave acknowledges the byte that follows a write address and takes it as the instruction. Bit 5 of that byte is loaded into `shdn_o` when the byte completes. Bits 7, 4, 3, 2, 1 and 0 have no effect.
- R4: The slave acknowledges the first data byte after the instruction. The wiper takes the byte's value at the end of its eighth clock.
- R5: Every further data byte in the same transfer is acknowledged and updates the wiper again under the same instruction.
- R6: When bit 6 of the instruction is set, each data byte sets the wiper to midscale 0x80 whatever its value.
- R7: After a read address is acknowledged, the slave sends the wiper value MSB first and releases SDA for the ninth clock.
- R8: A master ACK (SDA low on the ninth clock of a read byte) makes the slave send the wiper value again. A master NACK ends the transfer with SDA released.
- R9: A START or a STOP in the middle of a byte drops the partial byte and leaves the wiper unchanged. After a START the next byte is taken as an address.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: `wiper_o` and `shdn_o` change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Selects the lowest slave address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | WIPER_W | Current wiper setting |
| shdn_o | output | 1 | Stored shutdown flag |

## Verification
The assertions assume a master that moves SDA only while SCL is low, except when it makes START or STOP. They also assume every SCL phase lasts longer than the synchroniser delay plus one cycle, so the slave's response to a falling edge settles before SCL rises again. The bench master keeps every SCL quarter-phase at eight system clocks. It changes `addr_sel_i` only between transfers, and it issues a repeated START only while the slave has SDA released. The random transfers use the same bus tasks, so they stay within those limits too.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   localparam int BYTE_W        = 8;
   localparam int CNT_W         = $clog2(BYTE_W + 1);
   localparam int INSTR_MID_BIT = 6;
   localparam int INSTR_SD_BIT  = 5;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_INSTR,
      ST_INSTR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_RD_BYTE,
      ST_RD_ACK
   } dpot_state_e;

   typedef struct packed {
      logic midscale;
      logic shutdown;
   } dpot_instr_t;

   function automatic dpot_instr_t dpot_decode(input logic [BYTE_W-1:0] b);
      dpot_instr_t r;
      r.midscale = b[INSTR_MID_BIT];
      r.shutdown = b[INSTR_SD_BIT];
      return r;
   endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("dpot_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RST_VAL}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dpot_bus_events.sv
module dpot_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg #(
   parameter int WIPER_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic               load_mid,
   input  logic [WIPER_W-1:0] load_val,
   input  logic               sd_we,
   input  logic               sd_val,
   output logic [WIPER_W-1:0] wiper,
   output logic               sd_flag
);

   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper   <= MID;
         sd_flag <= 1'b0;
      end else begin
         if (load_en) wiper <= load_mid ? MID : load_val;
         if (sd_we)   sd_flag <= sd_val;
      end
   end

endmodule

// File: rtl/dpot_xfer_fsm.sv
module dpot_xfer_fsm
   import dpot_pkg::*;
#(
   parameter logic [5:0] ADDR_HI = 6'b010110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              addr_sel,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_oe,
   output logic              wr_en,
   output logic              wr_mid,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              sd_we,
   output logic              sd_val
);

   dpot_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   dpot_instr_t       instr;
   logic              rw;
   logic              mst_ack;
   logic              byte_end;
   logic              no_cond;
   logic [6:0]        my_addr;

   assign my_addr  = {ADDR_HI, addr_sel};
   assign no_cond  = ~start_det & ~stop_det;
   assign byte_end = scl_fall & (cnt == CNT_W'(BYTE_W)) & no_cond;

   assign wr_en   = (state == ST_DATA) & byte_end;
   assign wr_mid  = instr.midscale;
   assign wr_byte = shreg;
   assign sd_we   = (state == ST_INSTR) & byte_end;
   assign sd_val  = dpot_decode(shreg).shutdown;

   always_comb begin
      unique case (state)
         ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
         ST_RD_BYTE:                             sda_oe = ~txreg[BYTE_W-1];
         default:                                sda_oe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         txreg   <= '0;
         instr   <= '0;
         rw      <= 1'b0;
         mst_ack <= 1'b0;
      end else if (start_det) begin
         state <= ST_ADDR;
         cnt   <= '0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_ADDR, ST_INSTR, ST_DATA: begin
               if (scl_rise) begin
                  shreg <= {shreg[BYTE_W-2:0], sda_s};
                  cnt   <= cnt + 1'b1;
               end else if (byte_end) begin
                  cnt <= '0;
                  if (state == ST_ADDR) begin
                     if (shreg[BYTE_W-1:1] == my_addr) begin
                        rw    <= shreg[0];
                        txreg <= rd_byte;
                        state <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_INSTR) begin
                     instr <= dpot_decode(shreg);
                     state <= ST_INSTR_ACK;
                  end else begin
                     state <= ST_DATA_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  state <= rw ? ST_RD_BYTE : ST_INSTR;
                  cnt   <= '0;
               end
            end
            ST_INSTR_ACK, ST_DATA_ACK: begin
               if (scl_fall) begin
                  state <= ST_DATA;
                  cnt   <= '0;
               end
            end
            ST_RD_BYTE: begin
               if (scl_fall) begin
                  if (cnt == CNT_W'(BYTE_W - 1)) begin
                     state <= ST_RD_ACK;
                     cnt   <= '0;
                  end else begin
                     txreg <= {txreg[BYTE_W-2:0], 1'b0};
                     cnt   <= cnt + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  mst_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (mst_ack) begin
                     state <= ST_RD_BYTE;
                     txreg <= rd_byte;
                     cnt   <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
   import dpot_pkg::*;
#(
   parameter int         WIPER_W     = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [5:0] ADDR_HI     = 6'b010110
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic               addr_sel_i,
   output logic               sda_oe_o,
   output logic [WIPER_W-1:0] wiper_o,
   output logic               shdn_o
);

   localparam int PAD_W = BYTE_W - WIPER_W;

   generate
      if (WIPER_W < 1 || WIPER_W > BYTE_W) begin : g_bad_w
         $error("dpot_i2c_slave: WIPER_W must lie in 1..8");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic wr_en, wr_mid, sd_we, sd_val;
   logic [BYTE_W-1:0]  wr_byte;
   logic [BYTE_W-1:0]  rd_byte;
   logic [WIPER_W-1:0] wiper_q;
   logic [WIPER_W-1:0] load_val;

   dpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));

   dpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   dpot_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   dpot_xfer_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .sda_s(sda_s), .addr_sel(addr_sel_i), .rd_byte(rd_byte),
      .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_mid(wr_mid), .wr_byte(wr_byte),
      .sd_we(sd_we), .sd_val(sd_val));

   generate
      if (PAD_W == 0) begin : g_full
         assign rd_byte  = wiper_q;
         assign load_val = wr_byte;
      end else begin : g_narrow
         assign rd_byte  = {wiper_q, {PAD_W{1'b0}}};
         assign load_val = wr_byte[BYTE_W-1 -: WIPER_W];
      end
   endgenerate

   dpot_wiper_reg #(.WIPER_W(WIPER_W)) u_wiper (
      .clk(clk), .rst_n(rst_n),
      .load_en(wr_en), .load_mid(wr_mid), .load_val(load_val),
      .sd_we(sd_we), .sd_val(sd_val),
      .wiper(wiper_q), .sd_flag(shdn_o));

   assign wiper_o = wiper_q;

endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk #(
   parameter int WIPER_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               scl_i,
   input logic               sda_oe_o,
   input logic [WIPER_W-1:0] wiper_o,
   input logic               shdn_o
);

   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wiper_o == MID && !shdn_o && !sda_oe_o));

   // R10
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i);

   // R11
   wiper_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_o) |-> !scl_i);

   // R11
   shdn_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shdn_o) |-> !scl_i);

endmodule

bind dpot_i2c_slave dpot_i2c_chk #(.WIPER_W(WIPER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i),
   .sda_oe_o(sda_oe_o), .wiper_o(wiper_o), .shdn_o(shdn_o));

// File: tb/tb_dpot_i2c_slave.sv
`timescale 1ns/1ps
module tb_dpot_i2c_slave;

   localparam int Q     = 8;
   localparam int LIMIT = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_pull = 1'b0;
   logic       addr_sel = 1'b0;
   logic       sda_oe;
   logic [7:0] wiper;
   logic       shdn;
   wire        sda_line = ~(m_pull | sda_oe);

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_w = 8'h80;
   logic       exp_sd = 1'b0;
   int viol_oe = 0;
   int viol_ws = 0;
   logic       done = 1'b0;

   always #2.5 clk = ~clk;

   dpot_i2c_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .wiper_o(wiper), .shdn_o(shdn));

   function automatic logic [7:0] addr_byte(input logic sel, input logic rd);
      return {6'b010110, sel, rd};
   endfunction

   function automatic logic [7:0] apply_data(input logic [7:0] ins, input logic [7:0] d);
      return ins[6] ? 8'h80 : d;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor for R10 / R11: outputs may move only while SCL is low
   logic p_oe, p_sd;
   logic [7:0] p_w;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== p_oe && m_scl) viol_oe++;
         if ((wiper !== p_w || shdn !== p_sd) && m_scl) viol_ws++;
      end
      p_oe = sda_oe; p_w = wiper; p_sd = shdn;
   end

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_clk(input logic pull, output logic seen);
      m_pull = pull; wait_q();
      m_scl = 1'b1;  wait_q();
      seen = sda_line; wait_q();
      m_scl = 1'b0;  wait_q();
   endtask

   task automatic start_c();
      m_pull = 1'b1; wait_q();
      m_scl = 1'b0;  wait_q();
   endtask

   task automatic rstart_c();
      m_pull = 1'b0; wait_q();
      m_scl = 1'b1;  wait_q();
      m_pull = 1'b1; wait_q();
      m_scl = 1'b0;  wait_q();
   endtask

   task automatic stop_c();
      m_pull = 1'b1; wait_q();
      m_scl = 1'b1;  wait_q();
      m_pull = 1'b0; wait_q(); wait_q();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_clk(~b[i], s);
      bit_clk(1'b0, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_clk(1'b0, s);
         b[i] = s;
      end
      bit_clk(give_ack, s);
   endtask

   // full write transfer to the matching device, checking every byte
   task automatic do_write(input logic [7:0] ins, input int n, input logic [7:0] d0,
                           input bit rnd);
      logic a;
      logic [7:0] d;
      start_c();
      wr_byte(addr_byte(addr_sel, 1'b0), a);
      chk(a == 1'b1, "R2", "write address ack", a, 1);
      wr_byte(ins, a);
      chk(a == 1'b1, "R3", "instruction ack", a, 1);
      exp_sd = ins[5];
      chk(shdn == exp_sd, "R3", "shutdown flag", shdn, exp_sd);
      for (int k = 0; k < n; k++) begin
         d = rnd ? 8'($urandom) : d0 + 8'(k * 37);
         wr_byte(d, a);
         exp_w = apply_data(ins, d);
         chk(a == 1'b1, k == 0 ? "R4" : "R5", "data ack", a, 1);
         chk(wiper == exp_w, ins[6] ? "R6" : (k == 0 ? "R4" : "R5"),
             "wiper after data", wiper, exp_w);
      end
      stop_c();
   endtask

   task automatic do_read(input int n);
      logic a;
      logic [7:0] b;
      start_c();
      wr_byte(addr_byte(addr_sel, 1'b1), a);
      chk(a == 1'b1, "R2", "read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         rd_byte(k != n - 1, b);
         chk(b == exp_w, k == 0 ? "R7" : "R8", "read value", b, exp_w);
      end
      repeat (6) @(negedge clk);
      chk(sda_oe == 1'b0, "R8", "SDA released after NACK", sda_oe, 0);
      stop_c();
   endtask

   task automatic do_foreign(input logic [7:0] ins, input logic [7:0] d);
      logic a;
      start_c();
      wr_byte(addr_byte(~addr_sel, 1'b0), a);
      chk(a == 1'b0, "R2", "foreign address not acked", a, 0);
      wr_byte(ins, a);
      wr_byte(d, a);
      chk(a == 1'b0, "R2", "foreign data not acked", a, 0);
      chk(wiper == exp_w, "R2", "wiper untouched by foreign write", wiper, exp_w);
      chk(shdn == exp_sd, "R2", "shutdown untouched by foreign write", shdn, exp_sd);
      stop_c();
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic a;
      logic s;
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      // R1 during reset
      chk(wiper == 8'h80, "R1", "wiper in reset", wiper, 8'h80);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(wiper == 8'h80, "R1", "wiper after reset", wiper, 8'h80);
      chk(shdn == 1'b0, "R1", "shutdown after reset", shdn, 0);
      chk(sda_oe == 1'b0, "R1", "SDA released after reset", sda_oe, 0);

      // R4 R5: plain write, then several data bytes
      do_write(8'h00, 1, 8'h3C, 0);
      do_write(8'h00, 3, 8'h11, 0);
      // R3: shutdown set, then cleared; ignored bits do nothing
      do_write(8'h20, 1, 8'h55, 0);
      do_write(8'h9F, 2, 8'hA1, 0);
      // R6: midscale instruction overrides data
      do_write(8'h40, 2, 8'h12, 0);
      do_write(8'h00, 1, 8'hE7, 0);
      // R7 R8: repeated read
      do_read(3);
      // R2: other device address, both pin levels
      do_foreign(8'h40, 8'h01);
      addr_sel = 1'b1;
      do_foreign(8'h20, 8'h02);
      do_write(8'h00, 1, 8'h6B, 0);
      do_read(1);

      // R9: repeated START in the middle of a data byte
      start_c();
      wr_byte(addr_byte(addr_sel, 1'b0), a);
      wr_byte(8'h00, a);
      for (int i = 0; i < 4; i++) bit_clk(1'b0, s);
      rstart_c();
      chk(wiper == exp_w, "R9", "wiper after START abort", wiper, exp_w);
      wr_byte(addr_byte(addr_sel, 1'b0), a);
      chk(a == 1'b1, "R9", "address accepted after repeated START", a, 1);
      wr_byte(8'h00, a);
      wr_byte(8'h77, a);
      exp_w = 8'h77;
      chk(wiper == exp_w, "R9", "write after repeated START", wiper, exp_w);
      stop_c();

      // R9: STOP in the middle of a data byte
      start_c();
      wr_byte(addr_byte(addr_sel, 1'b0), a);
      wr_byte(8'h00, a);
      for (int i = 0; i < 3; i++) bit_clk(1'b1, s);
      stop_c();
      chk(wiper == exp_w, "R9", "wiper after STOP abort", wiper, exp_w);
      chk(sda_oe == 1'b0, "R9", "SDA released after STOP", sda_oe, 0);

      // constrained random traffic
      for (int t = 0; t < 30; t++) begin
         int kind;
         kind = int'($urandom_range(0, 5));
         addr_sel = 1'($urandom);
         if (kind <= 2)      do_write(8'($urandom), int'($urandom_range(1, 3)), 8'h00, 1);
         else if (kind <= 4) do_read(int'($urandom_range(1, 3)));
         else                do_foreign(8'($urandom), 8'($urandom));
      end

      chk(viol_oe == 0, "R10", "SDA enable moves with SCL high", viol_oe, 0);
      chk(viol_ws == 0, "R11", "wiper/shutdown move with SCL high", viol_ws, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule